// File: doc/BRIEF.md
# Single-Word Mailbox Bridge to a Serial Controller's Internal Registers

This block gives a host a single 64-bit mailbox through which it reaches the few internal configuration and status registers of a two-wire serial controller. The host composes a command word that carries a valid flag, a direction flag, an operation code, a 3-bit internal register index and a 32-bit data field, then writes it to the mailbox. The bridge decodes the word and performs the internal access. It then clears the valid flag. The host learns that the access has finished by polling that flag.

On a write access, the low bits of the data field go into the selected register. On a read access, the register value comes back zero-extended in the data field of the same word. Index 3 is direction dependent: a write to index 3 updates the clock divider setting, and a read from index 3 returns the live status byte supplied by the serial engine. A write to index 7 pulses a reset strobe towards the engine. The serial engine itself lies outside this block.

Top module: `mailbox_reg_bridge`

## Requirements
- R1: After reset the mailbox reads all zeros, every configuration output is zero and the engine reset strobe is low.
- R2: A host write is accepted only when bit 63 (valid) of the written word is 1 and bit 63 of the mailbox is 0; the mailbox then holds the written word on the next cycle. A write whose bit 63 is 0 leaves the mailbox unchanged.
- R3: After an accepted command, bit 63 of the mailbox reads 1 for exactly WAIT_CYC cycles (default 2) and then returns to 0.
- R4: A host write that arrives while bit 63 of the mailbox is 1 is ignored: the command in progress completes with its own result.
- R5: With operation code 6 in bits [60:57] and bit 56 clear (write), the low REG_W bits of [31:0] are stored into the register named by bits [34:32]: 0 slave address, 1 data, 2 control, 3 clock divider, 4 extended slave address.
- R6: A write with operation code 6 to index 7 raises the engine reset strobe for exactly one cycle and changes no stored register.
- R7: With operation code 6 and bit 56 set (read), bits [31:0] of the completed word hold the zero-extended value of the register named by index 0, 1, 2 or 4.
- R8: A read of index 3 returns the engine status input sampled in the completing cycle, not the clock divider value written to index 3.
- R9: An operation code other than 6, index 5 or 6, or a read of index 7 changes no register, raises no reset strobe and completes with [31:0] equal to zero.
- R10: On completion, bits [62:32] of the mailbox keep the values the host wrote, and a valid write with operation code 6 keeps its data field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_we | input | 1 | Host write strobe for the mailbox |
| cmd_wdata | input | 64 | Command word written by the host |
| mbox_rdata | output | 64 | Current mailbox contents for host polling |
| eng_status | input | REG_W | Status byte from the serial engine |
| cfg_slave_addr | output | REG_W | Slave address register (index 0) |
| cfg_data | output | REG_W | Data register (index 1) |
| cfg_ctrl | output | REG_W | Control register (index 2) |
| cfg_clkdiv | output | REG_W | Clock divider register (index 3, write side) |
| cfg_slave_addr_ext | output | REG_W | Extended slave address register (index 4) |
| eng_soft_reset | output | 1 | One-cycle reset strobe to the engine (index 7 write) |

## Verification
On every cycle the assertions check the handshake: valid never drops in the cycle right after it rises and always drops after completion. They also check that a write arriving while busy leaves the mailbox untouched, that the upper fields survive completion, that unused codes leave the registers and reset strobe quiet, that a status read returns the engine's input, and that the reset strobe lasts a single cycle. The bench scenarios are needed to show the exact busy length the host observes, the register that each index reaches in each direction, the data values that come back on reads, and the fact that a word with its valid flag clear is dropped.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int unsigned CMD_W   = 64;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned IDX_LO  = 32;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned RD_BIT  = 56;
  localparam int unsigned OP_LO   = 57;
  localparam int unsigned OP_W    = 4;
  localparam int unsigned VLD_BIT = 63;
  localparam logic [OP_W-1:0] OP_REG_ACCESS = 4'd6;

  typedef enum logic [IDX_W-1:0] {
    IX_SADDR     = 3'd0,
    IX_DATA      = 3'd1,
    IX_CTRL      = 3'd2,
    IX_CLK_STAT  = 3'd3,
    IX_SADDR_EXT = 3'd4,
    IX_RSV5      = 3'd5,
    IX_RSV6      = 3'd6,
    IX_ENG_RST   = 3'd7
  } idx_e;

  typedef struct packed {
    logic hit;
    logic rd;
    idx_e idx;
  } acc_s;
endpackage

// File: rtl/rb_decode.sv
module rb_decode
  import rb_pkg::*;
(
  input  logic [OP_W-1:0]  op,
  input  logic             rd,
  input  logic [IDX_W-1:0] idx,
  output acc_s             acc
);
  logic idx_ok;

  always_comb begin
    acc.rd  = rd;
    acc.idx = idx_e'(idx);
    unique case (idx_e'(idx))
      IX_RSV5, IX_RSV6: idx_ok = 1'b0;
      IX_ENG_RST:       idx_ok = !rd;
      default:          idx_ok = 1'b1;
    endcase
    acc.hit = (op == OP_REG_ACCESS) && idx_ok;
  end
endmodule

// File: rtl/rb_handshake.sv
module rb_handshake #(
  parameter int unsigned WAIT_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_we,
  input  logic cmd_vld,
  output logic accept,
  output logic done,
  output logic busy
);
  localparam int unsigned CW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
  localparam logic [CW-1:0] CNT_LOAD = CW'(WAIT_CYC - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  assign accept = cmd_we && cmd_vld && !busy_q;
  assign done   = busy_q && (cnt_q == '0);
  assign busy   = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q - 1'b1;
    end
  end

  assign en = accept || busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/rb_regs.sv
module rb_regs
  import rb_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  idx_e             idx,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] status,
  output logic [REG_W-1:0] rd_val,
  output logic [REG_W-1:0] slave_addr,
  output logic [REG_W-1:0] data,
  output logic [REG_W-1:0] ctrl,
  output logic [REG_W-1:0] clkdiv,
  output logic [REG_W-1:0] slave_addr_ext,
  output logic             soft_reset
);
  localparam int unsigned NSLOT = 5;

  logic [NSLOT-1:0] stb;
  logic [REG_W-1:0] slot_q [NSLOT];
  logic             srst_q, srst_d;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign stb[g] = wr_en && (int'(idx) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      slot_q[g] <= '0;
      else if (stb[g]) slot_q[g] <= wdata;
    end
  end

  always_comb begin
    unique case (idx)
      IX_SADDR:     rd_val = slot_q[0];
      IX_DATA:      rd_val = slot_q[1];
      IX_CTRL:      rd_val = slot_q[2];
      IX_CLK_STAT:  rd_val = status;
      IX_SADDR_EXT: rd_val = slot_q[4];
      default:      rd_val = '0;
    endcase
  end

  assign srst_d = wr_en && (idx == IX_ENG_RST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst_q <= 1'b0;
    else        srst_q <= srst_d;
  end

  assign slave_addr     = slot_q[0];
  assign data           = slot_q[1];
  assign ctrl           = slot_q[2];
  assign clkdiv         = slot_q[3];
  assign slave_addr_ext = slot_q[4];
  assign soft_reset     = srst_q;

  // R6: the engine reset strobe never lasts two cycles
  assert_rst_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q);
endmodule

// File: rtl/mailbox_reg_bridge.sv
module mailbox_reg_bridge
  import rb_pkg::*;
#(
  parameter int unsigned REG_W    = 8,
  parameter int unsigned WAIT_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [63:0]      cmd_wdata,
  output logic [63:0]      mbox_rdata,
  input  logic [REG_W-1:0] eng_status,
  output logic [REG_W-1:0] cfg_slave_addr,
  output logic [REG_W-1:0] cfg_data,
  output logic [REG_W-1:0] cfg_ctrl,
  output logic [REG_W-1:0] cfg_clkdiv,
  output logic [REG_W-1:0] cfg_slave_addr_ext,
  output logic             eng_soft_reset
);
  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic [CMD_W-1:0] mbox_q, mbox_d;
  logic             mbox_en;
  logic             accept, done, busy;
  acc_s             acc;
  logic [REG_W-1:0] rd_val;
  logic             reg_wr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  rb_handshake #(.WAIT_CYC(WAIT_CYC)) u_hs (
    .clk     (clk),
    .rst_n   (rst_ni),
    .cmd_we  (cmd_we),
    .cmd_vld (cmd_wdata[VLD_BIT]),
    .accept  (accept),
    .done    (done),
    .busy    (busy)
  );

  rb_decode u_dec (
    .op  (mbox_q[OP_LO +: OP_W]),
    .rd  (mbox_q[RD_BIT]),
    .idx (mbox_q[IDX_LO +: IDX_W]),
    .acc (acc)
  );

  assign reg_wr = done && acc.hit && !acc.rd;

  rb_regs #(.REG_W(REG_W)) u_regs (
    .clk            (clk),
    .rst_n          (rst_ni),
    .wr_en          (reg_wr),
    .idx            (acc.idx),
    .wdata          (mbox_q[REG_W-1:0]),
    .status         (eng_status),
    .rd_val         (rd_val),
    .slave_addr     (cfg_slave_addr),
    .data           (cfg_data),
    .ctrl           (cfg_ctrl),
    .clkdiv         (cfg_clkdiv),
    .slave_addr_ext (cfg_slave_addr_ext),
    .soft_reset     (eng_soft_reset)
  );

  always_comb begin
    mbox_d = mbox_q;
    if (accept) begin
      mbox_d = cmd_wdata;
    end else if (done) begin
      mbox_d[VLD_BIT] = 1'b0;
      if (!acc.hit)
        mbox_d[DATA_W-1:0] = '0;
      else if (acc.rd)
        mbox_d[DATA_W-1:0] = DATA_W'(rd_val);
    end
  end

  assign mbox_en = accept || done;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      mbox_q <= '0;
    else if (mbox_en) mbox_q <= mbox_d;
  end

  assign mbox_rdata = mbox_q;

  // R3: mailbox valid agrees with the handshake, stays up after rising, drops at completion
  assert_vld_tracks_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    mbox_q[VLD_BIT] == busy);
  assert_vld_hold_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(mbox_q[VLD_BIT]) |=> mbox_q[VLD_BIT]);
  assert_vld_clear_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !mbox_q[VLD_BIT]);
  // R4: writes during a pending access do not touch the mailbox
  assert_busy_ignore_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (mbox_q[VLD_BIT] && !done && cmd_we) |=> $stable(mbox_q));
  // R10: upper fields survive completion
  assert_fields_keep_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> (mbox_q[62:32] == $past(mbox_q[62:32])));
  // R9: unused codes are inert and return zero
  assert_unused_inert_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (done && !acc.hit) |=> (mbox_q[DATA_W-1:0] == '0) && !eng_soft_reset &&
      $stable({cfg_slave_addr, cfg_data, cfg_ctrl, cfg_clkdiv, cfg_slave_addr_ext}));
  // R8: a read of index 3 returns the engine status
  assert_rd_status_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (done && acc.hit && acc.rd && acc.idx == IX_CLK_STAT) |=>
      (mbox_q[DATA_W-1:0] == DATA_W'($past(eng_status))));
endmodule

// File: tb/mailbox_reg_bridge_test.sv
module mailbox_reg_bridge_test;
  localparam int unsigned REG_W = 8;
  localparam int unsigned WAIT_CYC = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b1;
  logic             cmd_we = 1'b0;
  logic [63:0]      cmd_wdata = '0;
  logic [63:0]      mbox_rdata;
  logic [REG_W-1:0] eng_status = '0;
  logic [REG_W-1:0] cfg_slave_addr, cfg_data, cfg_ctrl, cfg_clkdiv, cfg_slave_addr_ext;
  logic             eng_soft_reset;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  mailbox_reg_bridge #(.REG_W(REG_W), .WAIT_CYC(WAIT_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .mbox_rdata(mbox_rdata), .eng_status(eng_status),
    .cfg_slave_addr(cfg_slave_addr), .cfg_data(cfg_data), .cfg_ctrl(cfg_ctrl),
    .cfg_clkdiv(cfg_clkdiv), .cfg_slave_addr_ext(cfg_slave_addr_ext),
    .eng_soft_reset(eng_soft_reset)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act %0d cycles exp completion", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [3:0] op, input logic rd,
                                     input logic [2:0] idx, input logic [31:0] d);
    return (64'd1 << 63) | (64'(op) << 57) | (64'(rd) << 56) | (64'(idx) << 32) | 64'(d);
  endfunction

  task automatic host_wr(input logic [63:0] w);
    cmd_we = 1'b1;
    cmd_wdata = w;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  // issue, poll until valid drops, return completed word and busy length
  task automatic issue(input logic [63:0] w, output logic [63:0] res, output int busy_n);
    host_wr(w);
    busy_n = 0;
    for (int i = 0; i < 50; i++) begin
      if (!mbox_rdata[63]) break;
      busy_n++;
      @(negedge clk);
    end
    res = mbox_rdata;
  endtask

  task automatic t_reset;
    chk("R1 mailbox", mbox_rdata, 64'd0);
    chk("R1 cfg", {cfg_slave_addr, cfg_data, cfg_ctrl, cfg_clkdiv, cfg_slave_addr_ext}, '0);
    chk("R1 strobe", 64'(eng_soft_reset), 64'd0);
  endtask

  task automatic t_accept;
    logic [63:0] w;
    w = mk(4'd6, 1'b0, 3'd2, 32'hAB);
    host_wr(w);
    chk("R2 latched word", mbox_rdata, w);
    repeat (4) @(negedge clk);
    w = {1'b0, 63'h0123_4567_89AB_CDEF};
    host_wr(w);
    chk("R2 no-valid write ignored", mbox_rdata, mk(4'd6, 1'b0, 3'd2, 32'hAB) & ~(64'd1 << 63));
    chk("R2 ctrl from accepted write", 64'(cfg_ctrl), 64'hAB);
  endtask

  task automatic t_writes;
    logic [63:0] r;
    int n;
    logic [7:0] v [5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    for (int i = 0; i < 5; i++) begin
      issue(mk(4'd6, 1'b0, 3'(i), {24'hFFFFFF, v[i]}), r, n);
      chk("R3 busy length", 64'(n), 64'(WAIT_CYC));
      chk("R10 write word kept", r, mk(4'd6, 1'b0, 3'(i), {24'hFFFFFF, v[i]}) & ~(64'd1 << 63));
    end
    chk("R5 idx0", 64'(cfg_slave_addr), 64'h11);
    chk("R5 idx1", 64'(cfg_data), 64'h22);
    chk("R5 idx2", 64'(cfg_ctrl), 64'h33);
    chk("R5 idx3 clkdiv", 64'(cfg_clkdiv), 64'h44);
    chk("R5 idx4", 64'(cfg_slave_addr_ext), 64'h55);
  endtask

  task automatic t_reads;
    logic [63:0] r;
    int n;
    logic [7:0] e [5] = '{8'h11, 8'h22, 8'h33, 8'h00, 8'h55};
    for (int i = 0; i < 5; i++) begin
      if (i == 3) continue;
      issue(mk(4'd6, 1'b1, 3'(i), 32'hDEAD_BEEF), r, n);
      chk("R7 read data", r, (mk(4'd6, 1'b1, 3'(i), 32'h0) & ~(64'd1 << 63)) | 64'(e[i]));
    end
  endtask

  task automatic t_status;
    logic [63:0] r;
    int n;
    eng_status = 8'h5A;
    issue(mk(4'd6, 1'b1, 3'd3, 32'h0), r, n);
    chk("R8 status read", 64'(r[31:0]), 64'h5A);
    chk("R8 clkdiv untouched", 64'(cfg_clkdiv), 64'h44);
  endtask

  task automatic t_soft_reset;
    logic [63:0] r;
    int n;
    issue(mk(4'd6, 1'b0, 3'd7, 32'hFF), r, n);
    chk("R6 strobe high", 64'(eng_soft_reset), 64'd1);
    @(negedge clk);
    chk("R6 strobe one cycle", 64'(eng_soft_reset), 64'd0);
    chk("R6 regs unchanged", {cfg_slave_addr, cfg_data, cfg_ctrl, cfg_clkdiv, cfg_slave_addr_ext},
        64'h11_22_33_44_55);
  endtask

  task automatic t_unused;
    logic [63:0] r;
    int n;
    issue(mk(4'd5, 1'b0, 3'd0, 32'hFF), r, n);
    chk("R9 bad op data", 64'(r[31:0]), 64'd0);
    chk("R9 bad op no write", 64'(cfg_slave_addr), 64'h11);
    issue(mk(4'd6, 1'b1, 3'd5, 32'h1234), r, n);
    chk("R9 idx5 read", 64'(r[31:0]), 64'd0);
    issue(mk(4'd6, 1'b0, 3'd6, 32'h77), r, n);
    chk("R9 idx6 write", 64'(r[31:0]), 64'd0);
    chk("R9 no strobe", 64'(eng_soft_reset), 64'd0);
    issue(mk(4'd6, 1'b1, 3'd7, 32'h99), r, n);
    chk("R9 idx7 read", 64'(r[31:0]), 64'd0);
    chk("R9 regs unchanged", {cfg_slave_addr, cfg_data, cfg_ctrl, cfg_clkdiv, cfg_slave_addr_ext},
        64'h11_22_33_44_55);
  endtask

  task automatic t_busy_ignore;
    logic [63:0] r;
    host_wr(mk(4'd6, 1'b0, 3'd1, 32'hA1));
    host_wr(mk(4'd6, 1'b0, 3'd1, 32'hB2));
    for (int i = 0; i < 50; i++) begin
      if (!mbox_rdata[63]) break;
      @(negedge clk);
    end
    r = mbox_rdata;
    chk("R4 first command wins", 64'(cfg_data), 64'hA1);
    chk("R4 mailbox of first", r, mk(4'd6, 1'b0, 3'd1, 32'hA1) & ~(64'd1 << 63));
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_accept();
    t_writes();
    t_reads();
    t_status();
    t_soft_reset();
    t_unused();
    t_busy_ignore();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule